// File: doc/BRIEF.md
# Priority Pin Crossbar Allocator

This block routes a fixed set of peripheral signals onto a bank of general-purpose port pins. Pin positions are not tied to a signal. The allocator walks the peripherals in a fixed priority order. Each enabled peripheral takes the next free pins, starting from pin 0 and climbing. A per-pin skip mask reserves pins, and the allocator steps past them. As a result, switching one peripheral on or off moves every peripheral of lower priority.

The mapping is computed combinationally from the enable and skip inputs and captured in a map register. All pin assignments therefore change together on one clock edge. Peripheral data and output enables pass through the registered map without further delay. Pins that no peripheral claims act as plain GPIO. Peripheral inputs read back the pin they are mapped to.

Signal index layout (also the priority order):

| Signal index | Signal |
|---|---|
| 0 | first UART transmit |
| 1 | first UART receive |
| 2 | SPI clock |
| 3 | SPI MOSI |
| 4 | SPI MISO |
| 5 | SPI select |
| 6 | second UART transmit |
| 7 | second UART receive |

Enable bits: bit 0 controls the first UART, bit 1 the SPI unit, and bit 2 the second UART.

Top module: `pin_xbar`

## Requirements
- R1: Peripherals are placed in the priority order first UART (2 signals, indices 0–1), then SPI (4 signals, indices 2–5), then second UART (2 signals, indices 6–7). Enabled signals take free pins in ascending signal order. Pins are assigned in strictly increasing pin order.
- R2: With all three enable bits set and no skips, signals 0–7 occupy pins 0–7 respectively.
- R3: Clearing a higher-priority enable shifts every lower-priority peripheral down. With only the SPI enable clear, the second UART occupies pins 2–3.
- R4: A pin whose skip bit is 1 is never assigned. Following signals land on the next non-skipped pins in ascending order, even when those pins are not adjacent.
- R5: If the non-skipped pins run out, the signals that have not been placed drive no pin and `overflow_o` is 1. Otherwise `overflow_o` is 0.
- R6: A pin not assigned to any signal drives `gpio_out_i` and `gpio_oe_i` for that pin.
- R7: An assigned pin drives its signal's `sig_out_i` and `sig_oe_i`. Each pin is driven by at most one signal.
- R8: `sig_in_o` of a placed signal equals `pin_in_i` of its pin. The signal of a disabled peripheral, or a signal that was not placed, reads 1.
- R9: The map follows `periph_en_i` and `skip_i` as sampled at the most recent clock edge. Before that edge the previous map stays fully in force, and after it the new map applies to all pins at once.
- R10: While `rst_ni` is low, the map is empty: every pin is GPIO, every `sig_in_o` bit is 1, and `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| periph_en_i | input | 3 | Peripheral enable bits |
| skip_i | input | 32 | Per-pin reservation mask, 1 = skip |
| sig_out_i | input | 8 | Peripheral output values per signal |
| sig_oe_i | input | 8 | Peripheral output enables per signal |
| sig_in_o | output | 8 | Routed pin values back to each signal |
| gpio_out_i | input | 32 | GPIO output values for unassigned pins |
| gpio_oe_i | input | 32 | GPIO output enables for unassigned pins |
| pin_in_i | input | 32 | Sampled pin levels |
| pin_out_o | output | 32 | Pin drive values |
| pin_oe_o | output | 32 | Pin output enables |
| overflow_o | output | 1 | Some enabled signal could not be placed |

## Verification
The checker assumes that the enable and skip inputs are synchronous to `clk_i`. It compares the map against copies of those inputs taken at the previous edge. The bench changes configuration only on the falling edge, which keeps the stimulus inside that assumption. Random skip masks are drawn from both sparse and dense distributions, so that the overflow path is reached as well as the normal packing path. Data inputs change freely, because the checker properties depend only on the map and on the inputs that configure it.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int NUM_PERIPH = 3;

  function automatic int periph_sigs(int p);
    case (p)
      0:       return 2;
      1:       return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int periph_base(int p);
    int b;
    b = 0;
    for (int i = 0; i < p; i++) b += periph_sigs(i);
    return b;
  endfunction

  localparam int NUM_SIG = periph_base(NUM_PERIPH);

  function automatic int sig_owner(int s);
    int o;
    o = 0;
    for (int p = 0; p < NUM_PERIPH; p++)
      if (s >= periph_base(p) && s < periph_base(p) + periph_sigs(p)) o = p;
    return o;
  endfunction
endpackage

// File: rtl/pin_xbar_alloc.sv
module pin_xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_PERIPH-1:0]         en_i,
  input  logic [NUM_PINS-1:0]           skip_i,
  output logic [NUM_SIG-1:0]            valid_o,
  output logic [NUM_SIG-1:0][IDX_W-1:0] idx_o,
  output logic                          ovf_o
);
  // serial packing: each signal searches from the pin after the previous hit
  always_comb begin
    int   cur;
    logic hit;
    cur     = 0;
    hit     = 1'b0;
    valid_o = '0;
    idx_o   = '0;
    ovf_o   = 1'b0;
    for (int s = 0; s < NUM_SIG; s++) begin
      if (en_i[sig_owner(s)]) begin
        hit = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
          if (!hit && p >= cur && !skip_i[p]) begin
            hit      = 1'b1;
            idx_o[s] = IDX_W'(p);
            cur      = p + 1;
          end
        end
        if (hit) valid_o[s] = 1'b1;
        else     ovf_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_xbar_map_reg.sv
module pin_xbar_map_reg
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SIG-1:0]            valid_d_i,
  input  logic [NUM_SIG-1:0][IDX_W-1:0] idx_d_i,
  input  logic                          ovf_d_i,
  output logic [NUM_SIG-1:0]            valid_q_o,
  output logic [NUM_SIG-1:0][IDX_W-1:0] idx_q_o,
  output logic                          ovf_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q_o <= '0;
      idx_q_o   <= '0;
      ovf_q_o   <= 1'b0;
    end else begin
      valid_q_o <= valid_d_i;
      idx_q_o   <= idx_d_i;
      ovf_q_o   <= ovf_d_i;
    end
  end
endmodule

// File: rtl/pin_xbar_pin_mux.sv
module pin_xbar_pin_mux
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_SIG-1:0]            valid_i,
  input  logic [NUM_SIG-1:0][IDX_W-1:0] idx_i,
  input  logic [NUM_SIG-1:0]            sig_out_i,
  input  logic [NUM_SIG-1:0]            sig_oe_i,
  input  logic [NUM_PINS-1:0]           gpio_out_i,
  input  logic [NUM_PINS-1:0]           gpio_oe_i,
  output logic [NUM_PINS-1:0]           pin_out_o,
  output logic [NUM_PINS-1:0]           pin_oe_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      pin_out_o[p] = gpio_out_i[p];
      pin_oe_o[p]  = gpio_oe_i[p];
      for (int s = 0; s < NUM_SIG; s++) begin
        if (valid_i[s] && idx_i[s] == IDX_W'(p)) begin
          pin_out_o[p] = sig_out_i[s];
          pin_oe_o[p]  = sig_oe_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/pin_xbar_in_route.sv
module pin_xbar_in_route
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic [NUM_SIG-1:0]            valid_i,
  input  logic [NUM_SIG-1:0][IDX_W-1:0] idx_i,
  input  logic [NUM_PINS-1:0]           pin_in_i,
  output logic [NUM_SIG-1:0]            sig_in_o
);
  // unmapped signals idle high
  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    assign sig_in_o[s] = valid_i[s] ? pin_in_i[idx_i[s]] : 1'b1;
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PERIPH-1:0] periph_en_i,
  input  logic [NUM_PINS-1:0]   skip_i,
  input  logic [NUM_SIG-1:0]    sig_out_i,
  input  logic [NUM_SIG-1:0]    sig_oe_i,
  output logic [NUM_SIG-1:0]    sig_in_o,
  input  logic [NUM_PINS-1:0]   gpio_out_i,
  input  logic [NUM_PINS-1:0]   gpio_oe_i,
  input  logic [NUM_PINS-1:0]   pin_in_i,
  output logic [NUM_PINS-1:0]   pin_out_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic                  overflow_o
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [NUM_SIG-1:0]            next_valid, map_valid;
  logic [NUM_SIG-1:0][IDX_W-1:0] next_idx, map_idx;
  logic                          next_ovf;

  pin_xbar_alloc #(.NUM_PINS(NUM_PINS)) u_alloc (
    .en_i    (periph_en_i),
    .skip_i  (skip_i),
    .valid_o (next_valid),
    .idx_o   (next_idx),
    .ovf_o   (next_ovf)
  );

  pin_xbar_map_reg #(.NUM_PINS(NUM_PINS)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_d_i (next_valid),
    .idx_d_i   (next_idx),
    .ovf_d_i   (next_ovf),
    .valid_q_o (map_valid),
    .idx_q_o   (map_idx),
    .ovf_q_o   (overflow_o)
  );

  pin_xbar_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .valid_i    (map_valid),
    .idx_i      (map_idx),
    .sig_out_i  (sig_out_i),
    .sig_oe_i   (sig_oe_i),
    .gpio_out_i (gpio_out_i),
    .gpio_oe_i  (gpio_oe_i),
    .pin_out_o  (pin_out_o),
    .pin_oe_o   (pin_oe_o)
  );

  pin_xbar_in_route #(.NUM_PINS(NUM_PINS)) u_in (
    .valid_i  (map_valid),
    .idx_i    (map_idx),
    .pin_in_i (pin_in_i),
    .sig_in_o (sig_in_o)
  );
endmodule

// File: rtl/pin_xbar_checker.sv
module pin_xbar_checker
  import pin_xbar_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_PERIPH-1:0]         en_i,
  input logic [NUM_PINS-1:0]           skip_i,
  input logic [NUM_SIG-1:0]            map_valid_i,
  input logic [NUM_SIG-1:0][IDX_W-1:0] map_idx_i,
  input logic                          ovf_i,
  input logic [NUM_SIG-1:0]            sig_in_i
);
  logic [NUM_PERIPH-1:0] en_q;
  logic [NUM_PINS-1:0]   skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      skip_q <= '0;
    end else begin
      en_q   <= en_i;
      skip_q <= skip_i;
    end
  end

  logic [NUM_PINS-1:0][NUM_SIG-1:0] owners;
  always_comb begin
    owners = '0;
    for (int p = 0; p < NUM_PINS; p++)
      for (int s = 0; s < NUM_SIG; s++)
        owners[p][s] = map_valid_i[s] && (map_idx_i[s] == IDX_W'(p));
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    AST_PIN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(owners[p])); // R7
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig_chk
    AST_SKIP_HONOURED: assert property (@(posedge clk_i) disable iff (!rst_ni) map_valid_i[s] |-> !skip_q[map_idx_i[s]]); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (!ovf_i && en_q[sig_owner(s)]) |-> map_valid_i[s]); // R5
    AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_q[sig_owner(s)] |-> sig_in_i[s]); // R8
    if (s > 0) begin : g_order
      AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni) (map_valid_i[s] && map_valid_i[s-1]) |-> (map_idx_i[s] > map_idx_i[s-1])); // R1
    end
  end

  AST_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (en_i == en_q && skip_i == skip_q) |=> ($stable(map_valid_i) && $stable(map_idx_i) && $stable(ovf_i))); // R9
endmodule

bind pin_xbar pin_xbar_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (periph_en_i),
  .skip_i      (skip_i),
  .map_valid_i (map_valid),
  .map_idx_i   (map_idx),
  .ovf_i       (overflow_o),
  .sig_in_i    (sig_in_o)
);

// File: tb/pin_xbar_bench.sv
`timescale 1ns/1ps
module pin_xbar_bench;
  localparam int NP = 32;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    en = '0;
  logic [NP-1:0] skip = '0;
  logic [NS-1:0] s_out = '0, s_oe = '0, s_in;
  logic [NP-1:0] g_out = '0, g_oe = '0, p_in = '0, p_out, p_oe;
  logic          ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pin_xbar u_pin_xbar (
    .clk_i(clk), .rst_ni(rst_n), .periph_en_i(en), .skip_i(skip),
    .sig_out_i(s_out), .sig_oe_i(s_oe), .sig_in_o(s_in),
    .gpio_out_i(g_out), .gpio_oe_i(g_oe), .pin_in_i(p_in),
    .pin_out_o(p_out), .pin_oe_o(p_oe), .overflow_o(ovf)
  );

  function automatic int owner(int s);
    if (s < 2) return 0;
    if (s < 6) return 1;
    return 2;
  endfunction

  logic [NP-1:0] e_out, e_oe;
  logic [NS-1:0] e_in;
  logic          e_ovf;

  // reference: list free pins, then deal them out in signal order
  function automatic void model(input logic [2:0] m_en, input logic [NP-1:0] m_skip);
    int free_pins[NP];
    int nfree, k;
    nfree = 0;
    k = 0;
    for (int p = 0; p < NP; p++) if (!m_skip[p]) begin free_pins[nfree] = p; nfree++; end
    e_out = g_out;
    e_oe  = g_oe;
    e_in  = '1;
    e_ovf = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (m_en[owner(s)]) begin
        if (k < nfree) begin
          e_out[free_pins[k]] = s_out[s];
          e_oe[free_pins[k]]  = s_oe[s];
          e_in[s]             = p_in[free_pins[k]];
          k++;
        end else e_ovf = 1'b1;
      end
    end
  endfunction

  task automatic check_vec(string tag, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag, logic [2:0] m_en, logic [NP-1:0] m_skip);
    model(m_en, m_skip);
    check_vec(tag, "pin_out", p_out, e_out);
    check_vec(tag, "pin_oe", p_oe, e_oe);
    check_vec(tag, "sig_in", {{(NP-NS){1'b0}}, s_in}, {{(NP-NS){1'b0}}, e_in});
    check_vec(tag, "overflow", {{(NP-1){1'b0}}, ovf}, {{(NP-1){1'b0}}, e_ovf});
  endtask

  task automatic rand_data();
    s_out = NS'($urandom);
    s_oe  = NS'($urandom);
    g_out = $urandom;
    g_oe  = $urandom;
    p_in  = $urandom;
  endtask

  // apply config at negedge, let one edge load it, sample at next negedge
  task automatic apply(logic [2:0] n_en, logic [NP-1:0] n_skip);
    @(negedge clk);
    en   = n_en;
    skip = n_skip;
    rand_data();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mask_setup();
    s_oe = '1;
    g_oe = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0]    old_en;
    logic [NP-1:0] old_skip;
    void'($urandom(32'd20240611));
    en   = 3'b111;
    skip = '0;
    rand_data();
    repeat (3) @(negedge clk);
    check_all("R10", 3'b000, '0);
    rst_n = 1'b1;

    // R2: all enabled, packed on pins 0..7
    apply(3'b111, '0);
    check_all("R2", en, skip);
    mask_setup(); #1;
    check_vec("R2", "oe mask", p_oe, 32'h0000_00FF);

    // R3: SPI off -> second UART on pins 2..3
    apply(3'b101, '0);
    mask_setup(); p_in = 32'h0000_0008; #1;
    check_vec("R3", "oe mask", p_oe, 32'h0000_000F);
    check_vec("R3", "uart_b rx", {{(NP-1){1'b0}}, s_in[7]}, 32'd1);
    check_all("R3", en, skip);

    // R1: first UART off -> SPI at 0..3, second UART 4..5
    apply(3'b110, '0);
    mask_setup(); #1;
    check_vec("R1", "oe mask", p_oe, 32'h0000_003F);
    apply(3'b001, '0);
    mask_setup(); #1;
    check_vec("R1", "oe mask", p_oe, 32'h0000_0003);

    // R4: skip pins 0 and 2 -> 1,3,4..9
    apply(3'b111, 32'h0000_0005);
    mask_setup(); #1;
    check_vec("R4", "oe mask", p_oe, 32'h0000_03FA);
    check_all("R4", en, skip);

    // R5: only pins 0..3 free
    apply(3'b111, 32'hFFFF_FFF0);
    mask_setup(); #1;
    check_vec("R5", "oe mask", p_oe, 32'h0000_000F);
    check_vec("R5", "unplaced idle", {{(NP-4){1'b0}}, s_in[7:4]}, 32'h0000_000F);
    check_all("R5", en, skip);

    // R6: nothing enabled -> pure GPIO
    apply(3'b000, 32'h1234_5678);
    check_all("R6", en, skip);

    // R9: new config visible only after the edge
    apply(3'b111, '0);
    old_en = en; old_skip = skip;
    @(negedge clk);
    en = 3'b010; skip = 32'h0000_0003;
    rand_data();
    #1;
    check_all("R9", old_en, old_skip);
    @(posedge clk);
    @(negedge clk);
    check_all("R9", en, skip);

    // random mix of sparse and dense skip masks
    for (int i = 0; i < 400; i++) begin
      logic [NP-1:0] sk;
      sk = ($urandom_range(0, 3) == 0) ? ~($urandom & $urandom & $urandom)
                                       : ($urandom & $urandom & $urandom);
      apply(3'($urandom), sk);
      check_all("R7/R8", en, skip);
      rand_data(); #1;
      check_all("R7/R8", en, skip);
    end

    // R10: reset in the middle clears the map
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all("R10", 3'b000, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule